// File: doc/BRIEF.md
# Flash Bus Mode Controller

This block is the pin-level control front end of a byte-wide flash memory. It turns the power-down, chip-select, output-enable and write-enable pins into one bus mode per cycle. The modes are deep power-down, standby, output disable, read, write and an invalid write. In read mode it picks the byte for the data bus from one of three sources: the array data input, a fixed identifier code, or an internal status register. It also drives the enable for the tri-state data bus. The array itself, the program and erase sequencing, and the full command decoding live elsewhere. The block receives a decoded read-mode strobe and a program/erase strobe, and it accepts them only in a valid write cycle.

When the power-down pin is low, every other input is ignored. The read mode returns to array and the status register is reloaded with 0x80. A program or erase that is running at that moment is aborted, and the block under change is flagged as damaged. When the pin returns high, reads stay high-impedance for a wakeup interval and command strobes are ignored for a longer lockout interval. Both intervals are counted in clock cycles and set by parameters. The system reset acts as power-up and starts the same two intervals.

Top module: `flash_bus_ctrl`

## Requirements
- R1: With `ce_n` high (standby), `dq_oe` is 0 whatever `oe_n` is. While the engine is busy in standby, it keeps running and status bit 7 stays 0.
- R2: `dq_oe` is 1 only when `pwd_n`=1, `ce_n`=0, `oe_n`=0, `we_n`=1 and the wakeup interval is over. With `oe_n` high the bus is not driven. `dq_out` is 0 whenever `dq_oe` is 0.
- R3: While `pwd_n` is 0, the bus is not driven and command strobes are ignored. On every clock edge in this state, the read mode is set to array and the status register is set to 0x80.
- R4: After `pwd_n` rises or `rst_n` is released, `dq_oe` stays 0 for WAKE_CYC rising clock edges and may be 1 from edge WAKE_CYC on.
- R5: Command strobes are ignored until LOCK_CYC rising edges have passed since `pwd_n` rose or `rst_n` was released.
- R6: When `pwd_n` is 0 while `eng_busy` is 1, `eng_abort` is 1 in the same cycle. `blk_bad` is set at the next edge and stays set until `rst_n` goes low.
- R7: A read with `a9_hv`=1 returns the identifier whatever the read mode. The identifier is 0x89 for `a0`=0. For `a0`=1 it is 0x94 when TOP_BOOT=1 and 0x95 when TOP_BOOT=0.
- R8: `cmd_rd_stb` in an accepted write cycle (`ce_n`=0, `we_n`=0, `oe_n`=1) loads the read mode from `cmd_rd_sel` at that edge. The codes are 0 for array, 1 for identifier and 2 for status. Code 3 leaves the read mode unchanged.
- R9: `cmd_pe_stb` in an accepted write cycle raises `eng_start` in the same cycle, but only if `vpp_hi` is 1. If `vpp_hi` is 0, there is no start and status bit 3 is set at that edge.
- R10: A cycle with `ce_n`, `oe_n` and `we_n` all 0 is neither a read nor a write. The bus is not driven and strobes are ignored.
- R11: Status bit 7 equals the inverse of `eng_busy` sampled at the previous edge. The other status bits are 0 apart from bit 3.
- R12: `rst_n` low (asynchronous) clears `blk_bad`, sets the read mode to array and the status register to 0x80, and starts both intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| pwd_n | input | 1 | Power-down pin, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| a0 | input | 1 | Address bit 0, picks the identifier byte |
| a9_hv | input | 1 | High-voltage identifier request, as a digital level |
| vpp_hi | input | 1 | Program voltage present |
| cmd_rd_stb | input | 1 | Decoded read-mode command strobe |
| cmd_rd_sel | input | 2 | Requested read mode (0 array, 1 identifier, 2 status) |
| cmd_pe_stb | input | 1 | Decoded program/erase command strobe |
| eng_busy | input | 1 | Program/erase engine busy |
| array_dout | input | 8 | Data from the memory array |
| dq_out | output | 8 | Byte for the data bus |
| dq_oe | output | 1 | Data bus drive enable |
| eng_start | output | 1 | Start the program/erase engine |
| eng_abort | output | 1 | Abort the program/erase engine |
| blk_bad | output | 1 | Sticky flag: the block under change was left damaged |

## Verification
The bench samples the bus enable one edge before and one edge at the end of the wakeup interval. A counter that is off by one would drive stale data early or hold the bus too long. A strobe lands on the last locked-out cycle and must leave no trace, which exposes a lockout that opens one cycle early. The invalid write with all three pins low, and the reserved read-mode code 3, are each followed by a read that would show a wrongly loaded mode. Power-down is entered with the engine busy. This checks that the abort is raised at once, that the damage flag outlives the wakeup, and that both the read mode and the status byte come back reset.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [2:0] {
    BM_PWRDN, BM_STANDBY, BM_OUTDIS, BM_READ, BM_WRITE, BM_BADWR
  } bus_mode_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] MFR_CODE  = 8'h89;
  localparam logic [7:0] DEV_TOP   = 8'h94;
  localparam logic [7:0] DEV_BOT   = 8'h95;
  localparam logic [7:0] SR_INIT   = 8'h80;
  localparam int         SR_RDY    = 7;
  localparam int         SR_VPPERR = 3;

  // Pin priority: power-down, then chip select, then write enable, then output enable
  function automatic bus_mode_e decode_pins(logic pwd_n, logic ce_n, logic oe_n, logic we_n);
    if (!pwd_n)     return BM_PWRDN;
    else if (ce_n)  return BM_STANDBY;
    else if (!we_n) return oe_n ? BM_WRITE : BM_BADWR;
    else if (!oe_n) return BM_READ;
    else            return BM_OUTDIS;
  endfunction

  function automatic logic [7:0] ident_code(logic a0, logic top_boot);
    if (!a0) return MFR_CODE;
    return top_boot ? DEV_TOP : DEV_BOT;
  endfunction

endpackage

// File: rtl/fbc_interval.sv
module fbc_interval #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwd_n,
  output logic done
);
  localparam int W = $clog2(CYC + 2);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(CYC);
    else if (!pwd_n)     cnt <= W'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R4
  hold_after_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |=> !done);

endmodule

// File: rtl/fbc_cmd_state.sv
module fbc_cmd_state
  import flash_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd,
  input  logic       wr_ok,
  input  logic       cmd_rd_stb,
  input  logic [1:0] cmd_rd_sel,
  input  logic       cmd_pe_stb,
  input  logic       vpp_hi,
  input  logic       eng_busy,
  output rd_mode_e   rd_mode,
  output logic [7:0] sr,
  output logic       eng_start,
  output logic       eng_abort,
  output logic       blk_bad
);
  logic rd_req, pe_req, vpp_fail;

  assign rd_req    = wr_ok && cmd_rd_stb;
  assign pe_req    = wr_ok && cmd_pe_stb;
  assign vpp_fail  = pe_req && !vpp_hi;
  assign eng_start = pe_req && vpp_hi;
  assign eng_abort = pd && eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= RM_ARRAY;
      sr      <= SR_INIT;
      blk_bad <= 1'b0;
    end else begin
      if (eng_abort) blk_bad <= 1'b1;
      if (pd) begin
        rd_mode <= RM_ARRAY;
        sr      <= SR_INIT;
      end else begin
        sr[SR_RDY] <= !eng_busy;
        if (vpp_fail) sr[SR_VPPERR] <= 1'b1;
        if (rd_req && cmd_rd_sel != 2'd3) rd_mode <= rd_mode_e'(cmd_rd_sel);
      end
    end
  end

  // R3
  pd_resets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (sr == SR_INIT) && (rd_mode == RM_ARRAY));
  // R6
  abort_marks_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && eng_busy) |=> blk_bad);
  // R9
  vpp_low_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pe_stb && wr_ok && !vpp_hi) |=> sr[SR_VPPERR]);
  // R11
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd && eng_busy) |=> !sr[SR_RDY]);

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int WAKE_CYC = 6,
  parameter int LOCK_CYC = 10,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwd_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       a0,
  input  logic       a9_hv,
  input  logic       vpp_hi,
  input  logic       cmd_rd_stb,
  input  logic [1:0] cmd_rd_sel,
  input  logic       cmd_pe_stb,
  input  logic       eng_busy,
  input  logic [7:0] array_dout,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       eng_start,
  output logic       eng_abort,
  output logic       blk_bad
);
  bus_mode_e  mode;
  rd_mode_e   rd_mode;
  logic [7:0] sr;
  logic       wake_done, lock_done, wr_ok;
  logic [7:0] rd_byte;

  assign mode  = decode_pins(pwd_n, ce_n, oe_n, we_n);
  assign wr_ok = (mode == BM_WRITE) && lock_done;

  fbc_interval #(.CYC(WAKE_CYC)) i_wake (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .done(wake_done));

  fbc_interval #(.CYC(LOCK_CYC)) i_lock (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .done(lock_done));

  fbc_cmd_state i_cmd (
    .clk(clk), .rst_n(rst_n), .pd(mode == BM_PWRDN), .wr_ok(wr_ok),
    .cmd_rd_stb(cmd_rd_stb), .cmd_rd_sel(cmd_rd_sel), .cmd_pe_stb(cmd_pe_stb),
    .vpp_hi(vpp_hi), .eng_busy(eng_busy), .rd_mode(rd_mode), .sr(sr),
    .eng_start(eng_start), .eng_abort(eng_abort), .blk_bad(blk_bad));

  always_comb begin
    if (a9_hv) rd_byte = ident_code(a0, TOP_BOOT);
    else begin
      case (rd_mode)
        RM_IDENT:  rd_byte = ident_code(a0, TOP_BOOT);
        RM_STATUS: rd_byte = sr;
        default:   rd_byte = array_dout;
      endcase
    end
  end

  assign dq_oe  = (mode == BM_READ) && wake_done;
  assign dq_out = dq_oe ? rd_byte : 8'h00;

  // R2
  drive_needs_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (pwd_n && !ce_n && !oe_n && we_n));
  // R5
  lockout_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> lock_done);
  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe && !eng_start));

endmodule

// File: tb/test_flash_bus_ctrl.sv
module test_flash_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 6;
  localparam int LOCK = 10;

  logic clk = 0, rst_n = 0, pwd_n = 1, ce_n = 1, oe_n = 1, we_n = 1;
  logic a0 = 0, a9_hv = 0, vpp_hi = 0, cmd_rd_stb = 0, cmd_pe_stb = 0, eng_busy = 0;
  logic [1:0] cmd_rd_sel = 0;
  logic [7:0] array_dout = 8'h5A;
  logic [7:0] dq_out;
  logic dq_oe, eng_start, eng_abort, blk_bad;
  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_ctrl #(.WAKE_CYC(WAKE), .LOCK_CYC(LOCK), .TOP_BOOT(1'b0)) i_flash_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .a0(a0), .a9_hv(a9_hv), .vpp_hi(vpp_hi), .cmd_rd_stb(cmd_rd_stb),
    .cmd_rd_sel(cmd_rd_sel), .cmd_pe_stb(cmd_pe_stb), .eng_busy(eng_busy),
    .array_dout(array_dout), .dq_out(dq_out), .dq_oe(dq_oe), .eng_start(eng_start),
    .eng_abort(eng_abort), .blk_bad(blk_bad));

  // {ce_n, oe_n, we_n, a9_hv, a0, expected dq_oe, expected dq_out}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R1 standby, oe low
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R1 standby, oe high
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A},  // R2 array read
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 output disable
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R10 all low
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 write cycle
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h89},  // R7 maker code
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h95}   // R7 device code, bottom boot
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  // one write cycle carrying a read-mode strobe, then back to a read
  task automatic set_rd(input logic [1:0] sel, input logic c, input logic o, input logic w);
    pins(c, o, w); cmd_rd_sel = sel; cmd_rd_stb = 1;
    @(negedge clk);
    cmd_rd_stb = 0; pins(0, 0, 1);
    #1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset quiet", {dq_oe, dq_out}, 9'h000);
    chk("R12 blk_bad clear", {8'h00, blk_bad}, 9'h000);
    pins(0, 0, 1);
    rst_n = 1;
    for (int k = 1; k <= WAKE; k++) begin
      @(negedge clk);
      if (k == WAKE - 1) chk("R4 wake edge-1", {dq_oe, dq_out}, 9'h000);
      if (k == WAKE)     chk("R12 array after reset", {dq_oe, dq_out}, {1'b1, 8'h5A});
    end
    repeat (LOCK - WAKE) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      pins(VEC[i][13], VEC[i][12], VEC[i][11]);
      a9_hv = VEC[i][10]; a0 = VEC[i][9];
      #1;
      chk($sformatf("R1/R2/R7/R10 vec%0d", i), {dq_oe, dq_out}, VEC[i][8:0]);
      @(negedge clk);
    end
    a9_hv = 0; a0 = 0;

    // R8 read-mode commands
    set_rd(2'd2, 0, 1, 0);
    chk("R8 status mode", {dq_oe, dq_out}, {1'b1, 8'h80});
    set_rd(2'd1, 0, 1, 0);
    chk("R8 ident a0=0", {dq_oe, dq_out}, {1'b1, 8'h89});
    a0 = 1; #1;
    chk("R8 R7 ident a0=1", {dq_oe, dq_out}, {1'b1, 8'h95});
    a0 = 0;
    set_rd(2'd3, 0, 1, 0);
    chk("R8 code 3 ignored", {dq_oe, dq_out}, {1'b1, 8'h89});
    set_rd(2'd0, 0, 1, 0);
    chk("R8 array mode", {dq_oe, dq_out}, {1'b1, 8'h5A});

    // R10 invalid write cycle ignored
    set_rd(2'd2, 0, 0, 0);
    chk("R10 strobe ignored", {dq_oe, dq_out}, {1'b1, 8'h5A});

    // R9 program/erase start
    @(negedge clk);
    pins(0, 1, 0); cmd_pe_stb = 1; vpp_hi = 1; #1;
    chk("R9 start with vpp", {8'h00, eng_start}, 9'h001);
    vpp_hi = 0; #1;
    chk("R9 no start without vpp", {8'h00, eng_start}, 9'h000);
    @(negedge clk);
    cmd_pe_stb = 0;
    set_rd(2'd2, 0, 1, 0);
    chk("R9 vpp error bit", {dq_oe, dq_out}, {1'b1, 8'h88});

    // R11 ready bit and busy through standby
    eng_busy = 1;
    @(negedge clk); #1;
    chk("R11 busy", {dq_oe, dq_out}, {1'b1, 8'h08});
    pins(1, 0, 1);
    @(negedge clk); #1;
    chk("R1 standby while busy", {dq_oe, dq_out}, 9'h000);
    @(negedge clk);
    pins(0, 0, 1); #1;
    chk("R1 busy continues", {dq_oe, dq_out}, {1'b1, 8'h08});
    eng_busy = 0;
    @(negedge clk); #1;
    chk("R11 ready again", {dq_oe, dq_out}, {1'b1, 8'h88});

    // R6 / R3 power-down with engine busy
    eng_busy = 1;
    @(negedge clk);
    pwd_n = 0; pins(0, 1, 0); cmd_rd_sel = 2'd1; cmd_rd_stb = 1; #1;
    chk("R6 abort raised", {8'h00, eng_abort}, 9'h001);
    chk("R3 bus quiet in pd", {dq_oe, dq_out}, 9'h000);
    @(negedge clk);
    chk("R6 blk_bad set", {8'h00, blk_bad}, 9'h001);
    eng_busy = 0; cmd_rd_stb = 0;
    pins(0, 0, 1);
    @(negedge clk);
    pwd_n = 1;
    for (int k = 1; k <= WAKE; k++) begin
      @(negedge clk);
      if (k == WAKE - 1) chk("R4 wake after pd", {dq_oe, dq_out}, 9'h000);
      if (k == WAKE)     chk("R3 array after pd", {dq_oe, dq_out}, {1'b1, 8'h5A});
    end
    repeat (LOCK - WAKE) @(negedge clk);
    set_rd(2'd2, 0, 1, 0);
    chk("R3 status reloaded", {dq_oe, dq_out}, {1'b1, 8'h80});
    chk("R6 blk_bad sticky", {8'h00, blk_bad}, 9'h001);
    set_rd(2'd0, 0, 1, 0);

    // R5 lockout edge
    pwd_n = 0;
    @(negedge clk);
    pwd_n = 1;
    repeat (LOCK - 1) @(negedge clk);
    set_rd(2'd2, 0, 1, 0);
    chk("R5 strobe in lockout", {dq_oe, dq_out}, {1'b1, 8'h5A});
    set_rd(2'd2, 0, 1, 0);
    chk("R5 strobe after lockout", {dq_oe, dq_out}, {1'b1, 8'h80});

    // R12 reset clears the damage flag
    rst_n = 0; #1;
    chk("R12 blk_bad cleared", {8'h00, blk_bad}, 9'h000);
    chk("R12 bus quiet", {dq_oe, dq_out}, 9'h000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    summary();
  end

endmodule